// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block lets a host drive one raw NAND flash device, one atomic bus operation at a time, through a small 16-bit register port. The host loads a command byte or an address byte into its holding register, then writes a one-hot launch word into the trigger register. The block starts one of six operations: a command latch cycle, an address latch cycle, a page program from the internal page buffer, a page read into that buffer, an ID read, or a status read. It produces the CLE, ALE, WE#, RE# and per-device CE# strobes on an 8-bit flash bus.

The device ready/busy line never reaches the host. Before its first strobe, every operation waits inside the block until the synchronised line reads ready. Completion is reported by a sticky flag in bit 15 of the same trigger register, which the host polls. Page data is exchanged through a host window onto the page buffer. Each 16-bit word of that window carries two buffer bytes in big-endian order. A configuration register provides chip enable and a self-clearing soft reset.

Top module: `nand_op_seq`

## Requirements
- R1: The trigger register is at register offset 2. Writing it with exactly one of bits 5:0 set launches an operation: bit 0 command cycle, bit 1 address cycle, bit 2 page program, bit 3 page read, bit 4 ID read, bit 5 status read. A write with none or several of those bits set launches nothing.
- R2: A command cycle drives the low byte of the command register (offset 0, read back as written) on the bus. CLE is high one clock before WE# falls and stays high one clock after WE# rises. WE# is low for WE_LOW clocks and ALE stays low.
- R3: An address cycle behaves like R2, using ALE and the low byte of the address register (offset 1), with CLE low.
- R4: A page program sends PAGE_BYTES bytes from buffer index 0 upward. Each byte gets one WE# low pulse of WE_LOW clocks, with CLE and ALE low.
- R5: A page read gives PAGE_BYTES RE# pulses of RE_LOW clocks each. The byte on the bus during the last low clock of pulse k is stored at buffer index k.
- R6: An ID read stores ID_BYTES bytes and a status read stores one byte, both from buffer index 0. Other buffer bytes are left unchanged.
- R7: No operation strobes WE# or RE# while the ready/busy input is low. The operation starts once that input returns high.
- R8: Trigger bit 15 reads 1 from completion until the next accepted launch, which clears it by the next clock. While an operation runs, bits 5:0 read its one-hot code, and they read 0 when the block is idle.
- R9: A trigger write made while an operation is running is ignored.
- R10: Configuration register at offset 4: bit 7 is chip enable. Writing bit 6 starts a soft reset. For RST_CYCLES clocks bit 6 reads 1, the running operation is abandoned, the done flag and chip enable are cleared, and trigger and configuration writes are ignored.
- R11: The buffer address register at offset 3 holds a buffer select in bits 2:0 and a chip select in bits 6:5, both read back. CE# line k is low only when chip enable is set and the chip select equals k.
- R12: A host address with its top bit set addresses buffer word w, which reads and writes {byte 2w, byte 2w+1}. Host buffer writes are ignored while an operation runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | HA_W | Host address: top bit selects the buffer window, else register offset |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for host_addr |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_ce_n | output | NUM_CS | Device enables, active low |
| nand_dq_out | output | 8 | Bus data driven by the block |
| nand_dq_oe | output | 1 | Bus drive enable |
| nand_dq_in | input | 8 | Bus data from the device |
| nand_rb_n | input | 1 | Device ready (1) / busy (0) |

## Verification
The bench builds the block with a 16-byte page, a 4-byte ID, a 3-clock WE# pulse, a 2-clock RE# pulse and a 4-clock soft reset. This small setup allows every one of the 256 command bytes and 256 address bytes to be sent and compared at the bus. It also lets every page buffer word be checked after each program and read, and every chip-select and enable pair be covered. Because the page is short, the partial writes of the ID and status reads can be checked byte by byte against the previous page contents. The bench also holds ready/busy low to show that launches stall, that retriggers are ignored and that a soft reset abandons the stalled operation.

// File: rtl/nfs_pkg.sv
package nfs_pkg;

  // one-hot launch bit positions in the trigger word
  localparam int OP_CMD  = 0;
  localparam int OP_ADDR = 1;
  localparam int OP_PROG = 2;
  localparam int OP_PRD  = 3;
  localparam int OP_ID   = 4;
  localparam int OP_STAT = 5;
  localparam int OP_N    = 6;

  typedef logic [OP_N-1:0] op_t;

  localparam int CS_W   = 2;
  localparam int NUM_CS = 1 << CS_W;

  // register offsets inside the register region
  localparam logic [2:0] OFS_CMD  = 3'd0;
  localparam logic [2:0] OFS_ADDR = 3'd1;
  localparam logic [2:0] OFS_TRIG = 3'd2;
  localparam logic [2:0] OFS_BSEL = 3'd3;
  localparam logic [2:0] OFS_CFG  = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDY,
    ST_SETUP,
    ST_WLOW,
    ST_HOLD,
    ST_WGAP,
    ST_RLOW,
    ST_RGAP
  } seq_state_t;

endpackage

// File: rtl/nfs_buffer.sv
module nfs_buffer #(
  parameter int PAGE_BYTES = 16,
  localparam int IDX_W = $clog2(PAGE_BYTES),
  localparam int WA_W  = IDX_W - 1
) (
  input  logic             clk,
  input  logic             host_we,
  input  logic [WA_W-1:0]  host_word,
  input  logic [15:0]      host_wdata,
  output logic [15:0]      host_rword,
  input  logic             eng_we,
  input  logic [IDX_W-1:0] eng_idx,
  input  logic [7:0]       eng_wbyte,
  output logic [7:0]       eng_rbyte
);

  logic [7:0] mem [PAGE_BYTES];

  // storage array: no reset, engine has priority over the host
  always_ff @(posedge clk) begin
    for (int i = 0; i < PAGE_BYTES; i++) begin
      if (eng_we && (eng_idx == IDX_W'(i))) begin
        mem[i] <= eng_wbyte;
      end else if (host_we && (host_word == WA_W'(i / 2))) begin
        mem[i] <= ((i % 2) == 0) ? host_wdata[15:8] : host_wdata[7:0];
      end
    end
  end

  assign host_rword = {mem[{host_word, 1'b0}], mem[{host_word, 1'b1}]};
  assign eng_rbyte  = mem[eng_idx];

endmodule

// File: rtl/nfs_regs.sv
module nfs_regs
  import nfs_pkg::*;
#(
  parameter int RST_CYCLES = 4,
  localparam int SR_W = $clog2(RST_CYCLES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [2:0]      reg_ofs,
  input  logic [15:0]     wdata,
  input  logic            eng_busy,
  input  logic            eng_done,
  input  op_t             eng_op,
  output logic [7:0]      cmd_byte,
  output logic [7:0]      addr_byte,
  output logic            trig_wr,
  output op_t             trig_val,
  output logic [CS_W-1:0] cs_sel,
  output logic            ce_en,
  output logic            srst_active,
  output logic [15:0]     rdata
);

  logic [15:0]     cmd_q, cmd_d;
  logic [15:0]     addr_q, addr_d;
  logic [2:0]      bsel_q, bsel_d;
  logic [CS_W-1:0] cs_q, cs_d;
  logic            ce_q, ce_d;
  logic [SR_W-1:0] srst_q, srst_d;

  assign srst_active = (srst_q != '0);

  always_comb begin
    cmd_d  = cmd_q;
    addr_d = addr_q;
    bsel_d = bsel_q;
    cs_d   = cs_q;
    ce_d   = ce_q;
    srst_d = srst_active ? (srst_q - 1'b1) : srst_q;
    if (reg_wr) begin
      unique case (reg_ofs)
        OFS_CMD:  cmd_d  = wdata;
        OFS_ADDR: addr_d = wdata;
        OFS_BSEL: begin
          bsel_d = wdata[2:0];
          cs_d   = wdata[6:5];
        end
        OFS_CFG: begin
          if (!srst_active) begin
            if (wdata[6]) begin
              srst_d = SR_W'(RST_CYCLES);
              ce_d   = 1'b0;
            end else begin
              ce_d = wdata[7];
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      addr_q <= '0;
      bsel_q <= '0;
      cs_q   <= '0;
      ce_q   <= 1'b0;
      srst_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      bsel_q <= bsel_d;
      cs_q   <= cs_d;
      ce_q   <= ce_d;
      srst_q <= srst_d;
    end
  end

  assign trig_wr   = reg_wr && (reg_ofs == OFS_TRIG) && !srst_active;
  assign trig_val  = wdata[OP_N-1:0];
  assign cmd_byte  = cmd_q[7:0];
  assign addr_byte = addr_q[7:0];
  assign cs_sel    = cs_q;
  assign ce_en     = ce_q;

  always_comb begin
    unique case (reg_ofs)
      OFS_CMD:  rdata = cmd_q;
      OFS_ADDR: rdata = addr_q;
      OFS_TRIG: rdata = {eng_done, 9'd0, (eng_busy ? eng_op : op_t'(0))};
      OFS_BSEL: rdata = {9'd0, cs_q, 2'd0, bsel_q};
      OFS_CFG:  rdata = {8'd0, ce_q, srst_active, 6'd0};
      default:  rdata = 16'd0;
    endcase
  end

endmodule

// File: rtl/nfs_engine.sv
module nfs_engine
  import nfs_pkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int ID_BYTES   = 4,
  parameter int WE_LOW     = 2,
  parameter int RE_LOW     = 2,
  localparam int IDX_W = $clog2(PAGE_BYTES),
  localparam int MAXL  = (WE_LOW > RE_LOW) ? WE_LOW : RE_LOW,
  localparam int TM_W  = $clog2(MAXL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             trig_wr,
  input  op_t              trig_val,
  input  logic [7:0]       cmd_byte,
  input  logic [7:0]       addr_byte,
  input  logic [7:0]       buf_byte,
  input  logic             rb_ok,
  input  logic [7:0]       dq_in,
  output logic             cle,
  output logic             ale,
  output logic             we_n,
  output logic             re_n,
  output logic             dq_oe,
  output logic [7:0]       dq_out,
  output logic             buf_we,
  output logic [IDX_W-1:0] buf_idx,
  output logic             busy,
  output logic             done,
  output op_t              op
);

  localparam logic [TM_W-1:0]  WE_LAST   = TM_W'(WE_LOW - 1);
  localparam logic [TM_W-1:0]  RE_LAST   = TM_W'(RE_LOW - 1);
  localparam logic [IDX_W-1:0] PAGE_LAST = IDX_W'(PAGE_BYTES - 1);
  localparam logic [IDX_W-1:0] ID_LAST   = IDX_W'(ID_BYTES - 1);

  seq_state_t       st_q, st_d;
  op_t              op_q, op_d;
  logic [TM_W-1:0]  tm_q, tm_d;
  logic [IDX_W-1:0] bc_q, bc_d;
  logic             done_q, done_d;
  logic             cap_we;
  logic             bus_cycle;
  logic [IDX_W-1:0] rd_last;

  assign bus_cycle = op_q[OP_CMD] | op_q[OP_ADDR];

  always_comb begin
    if (op_q[OP_PRD])     rd_last = PAGE_LAST;
    else if (op_q[OP_ID]) rd_last = ID_LAST;
    else                  rd_last = '0;
  end

  // next-state logic
  always_comb begin
    st_d   = st_q;
    op_d   = op_q;
    tm_d   = tm_q;
    bc_d   = bc_q;
    done_d = done_q;
    cap_we = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (trig_wr && $onehot(trig_val)) begin
          op_d   = trig_val;
          done_d = 1'b0;
          bc_d   = '0;
          tm_d   = '0;
          st_d   = ST_RDY;
        end
      end
      ST_RDY: begin
        if (rb_ok) begin
          tm_d = '0;
          if (bus_cycle)         st_d = ST_SETUP;
          else if (op_q[OP_PROG]) st_d = ST_WLOW;
          else                    st_d = ST_RLOW;
        end
      end
      ST_SETUP: st_d = ST_WLOW;
      ST_WLOW: begin
        if (tm_q == WE_LAST) st_d = bus_cycle ? ST_HOLD : ST_WGAP;
        else                 tm_d = tm_q + 1'b1;
      end
      ST_HOLD: begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end
      ST_WGAP: begin
        if (bc_q == PAGE_LAST) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          bc_d = bc_q + 1'b1;
          tm_d = '0;
          st_d = ST_WLOW;
        end
      end
      ST_RLOW: begin
        if (tm_q == RE_LAST) begin
          cap_we = 1'b1;
          st_d   = ST_RGAP;
        end else begin
          tm_d = tm_q + 1'b1;
        end
      end
      ST_RGAP: begin
        if (bc_q == rd_last) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          bc_d = bc_q + 1'b1;
          tm_d = '0;
          st_d = ST_RLOW;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (srst) begin
      st_d   = ST_IDLE;
      done_d = 1'b0;
      cap_we = 1'b0;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= '0;
      tm_q   <= '0;
      bc_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      tm_q   <= tm_d;
      bc_q   <= bc_d;
      done_q <= done_d;
    end
  end

  logic latch_phase;
  assign latch_phase = (st_q == ST_SETUP) || (st_q == ST_WLOW) || (st_q == ST_HOLD);

  assign cle     = op_q[OP_CMD] && latch_phase;
  assign ale     = op_q[OP_ADDR] && latch_phase;
  assign we_n    = (st_q != ST_WLOW);
  assign re_n    = (st_q != ST_RLOW);
  assign dq_oe   = latch_phase || (st_q == ST_WGAP);
  assign dq_out  = op_q[OP_CMD] ? cmd_byte : (op_q[OP_ADDR] ? addr_byte : buf_byte);
  assign buf_we  = cap_we;
  assign buf_idx = bc_q;
  assign busy    = (st_q != ST_IDLE);
  assign done    = done_q;
  assign op      = op_q;

  // dq_in is consumed by the buffer write path at the top level
  logic unused_dq;
  assign unused_dq = ^dq_in;

endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq
  import nfs_pkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int ID_BYTES   = 4,
  parameter int WE_LOW     = 2,
  parameter int RE_LOW     = 2,
  parameter int RST_CYCLES = 4,
  localparam int IDX_W = $clog2(PAGE_BYTES),
  localparam int WA_W  = IDX_W - 1,
  localparam int HA_W  = ((WA_W > 3) ? WA_W : 3) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HA_W-1:0]   host_addr,
  input  logic              host_wr,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [NUM_CS-1:0] nand_ce_n,
  output logic [7:0]        nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [7:0]        nand_dq_in,
  input  logic              nand_rb_n
);

  // reset: asynchronous assert, synchronous release
  logic rst_m_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_m_q    <= 1'b1;
      rst_sync_n <= rst_m_q;
    end
  end

  // ready/busy synchroniser
  logic rb_m_q, rb_s_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rb_m_q <= 1'b0;
      rb_s_q <= 1'b0;
    end else begin
      rb_m_q <= nand_rb_n;
      rb_s_q <= rb_m_q;
    end
  end

  logic buf_region;
  assign buf_region = host_addr[HA_W-1];

  logic            trig_wr;
  op_t             trig_val;
  logic [7:0]      cmd_byte, addr_byte;
  logic [CS_W-1:0] cs_sel;
  logic            ce_en, srst_active;
  logic [15:0]     reg_rdata, buf_rword;
  logic            eng_busy, eng_done;
  op_t             eng_op;
  logic            buf_we;
  logic [IDX_W-1:0] buf_idx;
  logic [7:0]      buf_byte;

  nfs_regs #(.RST_CYCLES(RST_CYCLES)) u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .reg_wr      (host_wr && !buf_region),
    .reg_ofs     (host_addr[2:0]),
    .wdata       (host_wdata),
    .eng_busy    (eng_busy),
    .eng_done    (eng_done),
    .eng_op      (eng_op),
    .cmd_byte    (cmd_byte),
    .addr_byte   (addr_byte),
    .trig_wr     (trig_wr),
    .trig_val    (trig_val),
    .cs_sel      (cs_sel),
    .ce_en       (ce_en),
    .srst_active (srst_active),
    .rdata       (reg_rdata)
  );

  nfs_engine #(
    .PAGE_BYTES (PAGE_BYTES),
    .ID_BYTES   (ID_BYTES),
    .WE_LOW     (WE_LOW),
    .RE_LOW     (RE_LOW)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .srst      (srst_active),
    .trig_wr   (trig_wr),
    .trig_val  (trig_val),
    .cmd_byte  (cmd_byte),
    .addr_byte (addr_byte),
    .buf_byte  (buf_byte),
    .rb_ok     (rb_s_q),
    .dq_in     (nand_dq_in),
    .cle       (nand_cle),
    .ale       (nand_ale),
    .we_n      (nand_we_n),
    .re_n      (nand_re_n),
    .dq_oe     (nand_dq_oe),
    .dq_out    (nand_dq_out),
    .buf_we    (buf_we),
    .buf_idx   (buf_idx),
    .busy      (eng_busy),
    .done      (eng_done),
    .op        (eng_op)
  );

  nfs_buffer #(.PAGE_BYTES(PAGE_BYTES)) u_buffer (
    .clk        (clk),
    .host_we    (host_wr && buf_region && !eng_busy),
    .host_word  (host_addr[WA_W-1:0]),
    .host_wdata (host_wdata),
    .host_rword (buf_rword),
    .eng_we     (buf_we),
    .eng_idx    (buf_idx),
    .eng_wbyte  (nand_dq_in),
    .eng_rbyte  (buf_byte)
  );

  assign host_rdata = buf_region ? buf_rword : reg_rdata;

  // per-device enables
  for (genvar k = 0; k < NUM_CS; k++) begin : g_ce
    assign nand_ce_n[k] = !(ce_en && (cs_sel == CS_W'(k)));
  end

endmodule

// File: rtl/nfs_checker.sv
module nfs_checker
  import nfs_pkg::*;
#(
  parameter int WE_LOW = 2,
  parameter int RE_LOW = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cle,
  input logic              ale,
  input logic              we_n,
  input logic              re_n,
  input logic [NUM_CS-1:0] ce_n,
  input logic              busy,
  input logic              done,
  input op_t               op,
  input logic              srst
);

  logic [15:0] we_run, re_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run <= '0;
      re_run <= '0;
    end else begin
      we_run <= we_n ? 16'd0 : we_run + 16'd1;
      re_run <= re_n ? 16'd0 : re_run + 16'd1;
    end
  end

  assert_latch_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale) && !(!we_n && !re_n));

  assert_cle_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(we_n) && cle) |-> $past(cle));

  assert_cle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(we_n) && $past(cle)) |-> cle);

  assert_ale_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(we_n) && ale) |-> $past(ale));

  assert_ale_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(we_n) && $past(ale)) |-> ale);

  assert_we_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (we_run == 16'(WE_LOW)));

  assert_re_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(re_n) |-> (re_run == 16'(RE_LOW)));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_op_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(op));

  assert_srst_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!busy && we_n && re_n));

  assert_ce_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ce_n) <= 1);

endmodule

bind nand_op_seq nfs_checker #(.WE_LOW(WE_LOW), .RE_LOW(RE_LOW)) u_nfs_checker (
  .clk   (clk),
  .rst_n (rst_n),
  .cle   (nand_cle),
  .ale   (nand_ale),
  .we_n  (nand_we_n),
  .re_n  (nand_re_n),
  .ce_n  (nand_ce_n),
  .busy  (eng_busy),
  .done  (eng_done),
  .op    (eng_op),
  .srst  (srst_active)
);

// File: tb/nand_op_seq_test.sv
module nand_op_seq_test;

  localparam int PB   = 16;
  localparam int IDB  = 4;
  localparam int WEL  = 3;
  localparam int REL  = 2;
  localparam int RSTC = 4;
  localparam int HA_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [HA_W-1:0] host_addr = '0;
  logic host_wr = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic cle, ale, we_n, re_n, dq_oe;
  logic [3:0] ce_n;
  logic [7:0] dq_out;
  logic [7:0] dq_in = 8'h00;
  logic rb_n = 1'b1;

  always #4 clk = ~clk;

  nand_op_seq #(
    .PAGE_BYTES (PB),
    .ID_BYTES   (IDB),
    .WE_LOW     (WEL),
    .RE_LOW     (REL),
    .RST_CYCLES (RSTC)
  ) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_addr   (host_addr),
    .host_wr     (host_wr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .nand_cle    (cle),
    .nand_ale    (ale),
    .nand_we_n   (we_n),
    .nand_re_n   (re_n),
    .nand_ce_n   (ce_n),
    .nand_dq_out (dq_out),
    .nand_dq_oe  (dq_oe),
    .nand_dq_in  (dq_in),
    .nand_rb_n   (rb_n)
  );

  int checks = 0;
  int errors = 0;

  // device model: write-strobe capture and read data source
  int wn = 0;
  logic [7:0] w_dq [64];
  logic w_cle [64];
  logic w_ale [64];
  int rk = 0;
  logic [7:0] rd_base = 8'h00;
  int we_low_cnt = 0;
  int re_low_cnt = 0;

  always @(posedge we_n) begin
    if (wn < 64) begin
      w_dq[wn] = dq_out;
      w_cle[wn] = cle;
      w_ale[wn] = ale;
    end
    wn = wn + 1;
  end

  always @(negedge re_n) begin
    dq_in = rd_base + 8'(rk * 13);
    rk = rk + 1;
  end

  always @(negedge clk) begin
    if (we_n === 1'b0) we_low_cnt++;
    if (re_n === 1'b0) re_low_cnt++;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", wd);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [HA_W-1:0] a, input logic [15:0] d);
    @(negedge clk);
    host_addr = a;
    host_wdata = d;
    host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [HA_W-1:0] a, output logic [15:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic model_clear();
    wn = 0;
    rk = 0;
    we_low_cnt = 0;
    re_low_cnt = 0;
  endtask

  task automatic wait_done(input string req);
    logic [15:0] d;
    bit seen;
    seen = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      hread(4'd2, d);
      if (d[15]) begin
        seen = 1'b1;
        break;
      end
    end
    if (!seen) chk(1'b0, req, 0, 1);
  endtask

  function automatic logic [7:0] pat(input int r, input int i);
    return 8'((i * 29) + (r * 7) + 3);
  endfunction

  function automatic logic [7:0] rbyte(input logic [7:0] base, input int k);
    return base + 8'(k * 13);
  endfunction

  logic [7:0] img [PB];

  initial begin
    logic [15:0] d;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    hread(4'd2, d); chk(d == 16'h0000, "R8 reset trigger", d, 0);
    hread(4'd4, d); chk(d == 16'h0000, "R10 reset config", d, 0);
    chk(ce_n == 4'hF && we_n && re_n && !cle && !ale, "R11 reset strobes",
        {ce_n, we_n, re_n, cle, ale}, 8'hFC);

    // R2: every command byte
    for (int c = 0; c < 256; c++) begin
      hwrite(4'd0, {~8'(c), 8'(c)});
      model_clear();
      hwrite(4'd2, 16'h0001);
      wait_done("R2 completion");
      ok = (wn == 1) && w_cle[0] && !w_ale[0] && (w_dq[0] == 8'(c)) && (we_low_cnt == WEL);
      chk(ok, "R2 command cycle", {wn[7:0], w_dq[0]}, {8'd1, 8'(c)});
    end
    hread(4'd0, d); chk(d == 16'h00FF, "R2 command readback", d, 16'h00FF);

    // R3: every address byte
    for (int c = 0; c < 256; c++) begin
      hwrite(4'd1, {8'(c), 8'(c) ^ 8'h5A});
      model_clear();
      hwrite(4'd2, 16'h0002);
      wait_done("R3 completion");
      ok = (wn == 1) && !w_cle[0] && w_ale[0] && (w_dq[0] == (8'(c) ^ 8'h5A)) && (we_low_cnt == WEL);
      chk(ok, "R3 address cycle", w_dq[0], 8'(c) ^ 8'h5A);
    end

    // R4 / R12: page program rounds
    for (int r = 0; r < 3; r++) begin
      for (int w = 0; w < PB / 2; w++)
        hwrite(4'(8 + w), {pat(r, 2 * w), pat(r, 2 * w + 1)});
      hread(4'(8 + 3), d);
      chk(d == {pat(r, 6), pat(r, 7)}, "R12 buffer word big-endian", d, {pat(r, 6), pat(r, 7)});
      model_clear();
      hwrite(4'd2, 16'h0004);
      hread(4'd2, d);
      chk(d == 16'h0004, "R8 done cleared and op shown", d, 16'h0004);
      wait_done("R4 completion");
      chk(wn == PB && we_low_cnt == PB * WEL, "R4 pulse count", wn, PB);
      for (int i = 0; i < PB; i++)
        chk(w_dq[i] == pat(r, i) && !w_cle[i] && !w_ale[i], "R4 program byte", w_dq[i], pat(r, i));
    end

    // R5: page reads
    for (int r = 0; r < 3; r++) begin
      rd_base = 8'(8'h11 + r * 40);
      model_clear();
      hwrite(4'd2, 16'h0008);
      wait_done("R5 completion");
      chk(rk == PB && re_low_cnt == PB * REL && wn == 0, "R5 read pulses", rk, PB);
      for (int w = 0; w < PB / 2; w++) begin
        hread(4'(8 + w), d);
        chk(d == {rbyte(rd_base, 2 * w), rbyte(rd_base, 2 * w + 1)}, "R5 page byte pair", d,
            {rbyte(rd_base, 2 * w), rbyte(rd_base, 2 * w + 1)});
      end
      for (int i = 0; i < PB; i++) img[i] = rbyte(rd_base, i);
    end

    // R6: ID read then status read
    rd_base = 8'h40;
    model_clear();
    hwrite(4'd2, 16'h0010);
    wait_done("R6 completion");
    for (int i = 0; i < IDB; i++) img[i] = rbyte(8'h40, i);
    chk(rk == IDB, "R6 ID pulse count", rk, IDB);
    for (int w = 0; w < PB / 2; w++) begin
      hread(4'(8 + w), d);
      chk(d == {img[2 * w], img[2 * w + 1]}, "R6 ID buffer", d, {img[2 * w], img[2 * w + 1]});
    end
    rd_base = 8'hE0;
    model_clear();
    hwrite(4'd2, 16'h0020);
    wait_done("R6 completion");
    img[0] = 8'hE0;
    chk(rk == 1, "R6 status pulse count", rk, 1);
    for (int w = 0; w < 2; w++) begin
      hread(4'(8 + w), d);
      chk(d == {img[2 * w], img[2 * w + 1]}, "R6 status buffer", d, {img[2 * w], img[2 * w + 1]});
    end

    // R1: non-one-hot trigger words launch nothing, done stays set
    hwrite(4'd2, 16'h0003);
    hwrite(4'd2, 16'h0030);
    hwrite(4'd2, 16'h0000);
    model_clear();
    repeat (10) @(negedge clk);
    hread(4'd2, d);
    chk(d == 16'h8000 && wn == 0 && rk == 0, "R1 invalid trigger ignored", d, 16'h8000);

    // R7 / R9 / R12: stall on busy
    rb_n = 1'b0;
    repeat (3) @(negedge clk);
    hwrite(4'd0, 16'h00C3);
    model_clear();
    hwrite(4'd2, 16'h0001);
    hwrite(4'd2, 16'h0002);
    hwrite(4'd8, 16'hDEAD);
    repeat (20) @(negedge clk);
    chk(wn == 0 && we_low_cnt == 0, "R7 no strobe while busy", wn, 0);
    hread(4'd2, d);
    chk(d == 16'h0001, "R9 retrigger ignored", d, 16'h0001);
    hread(4'd8, d);
    chk(d == {img[0], img[1]}, "R12 buffer write ignored while running", d, {img[0], img[1]});
    rb_n = 1'b1;
    wait_done("R7 completion");
    chk(wn == 1 && w_cle[0] && !w_ale[0] && w_dq[0] == 8'hC3, "R7 R9 operation after ready", w_dq[0], 8'hC3);

    // R11: chip-select and enable sweep
    for (int cs = 0; cs < 4; cs++) begin
      for (int en = 0; en < 2; en++) begin
        hwrite(4'd3, 16'((cs << 5) | ((cs ^ 5) & 7)));
        hwrite(4'd4, 16'(en << 7));
        hread(4'd3, d);
        chk(d == 16'((cs << 5) | ((cs ^ 5) & 7)), "R11 select readback", d, (cs << 5) | ((cs ^ 5) & 7));
        chk(ce_n == (en != 0 ? ~(4'b1 << cs) : 4'hF), "R11 enable lines", ce_n,
            en != 0 ? ~(4'b1 << cs) : 4'hF);
      end
    end

    // R10: soft reset abandons a stalled read
    hwrite(4'd4, 16'h0080);
    rb_n = 1'b0;
    repeat (3) @(negedge clk);
    model_clear();
    hwrite(4'd2, 16'h0008);
    hwrite(4'd4, 16'h00C0);
    hread(4'd4, d);
    chk(d == 16'h0040, "R10 reset in progress", d, 16'h0040);
    hwrite(4'd4, 16'h0080);
    repeat (RSTC + 2) @(negedge clk);
    hread(4'd4, d);
    chk(d == 16'h0000, "R10 reset ends, enable cleared", d, 0);
    hread(4'd2, d);
    chk(d == 16'h0000, "R10 operation abandoned", d, 0);
    chk(ce_n == 4'hF, "R10 enables released", ce_n, 4'hF);
    rb_n = 1'b1;
    repeat (12) @(negedge clk);
    chk(rk == 0 && wn == 0, "R10 no strobe after abort", rk, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule